// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a byte-wide direct register bus reach a bank of 16-bit indirect registers through three direct addresses. There is a control byte at 0x6E, an offset byte at 0x6F and a data byte at 0xA0. The control byte chooses the table, the port group and the direction. Writing the offset byte starts an access. For a read, the chosen byte is fetched into the data byte, and software can then read it at 0xA0. For a write, the next write to 0xA0 stores the byte in the indirect register that the offset points to.

Only one table is built: the power-saving table, with table code 001. It is a register array made of one global group and one group for each port. Every group has the same number of 16-bit words, and each word is reached as two byte offsets. One word, the low-power recovery timer at offsets 0x2E and 0x2F, has its upper byte reserved. Its lower byte resets to 0x27, a count in units of 640 ns.

A direct read returns the value one clock after the address is presented.

Top module: `idx_reg_bridge`

## Requirements
- R1: After a synchronous reset, the control byte, the offset byte and the data byte read 0x00, every indirect word is 0x0000, and each group's recovery word is 0x0027.
- R2: A bus write to 0x6E or 0x6F stores the byte, and a bus read of that address returns the stored byte.
- R3: With control bits 7:5 = 001, bit 4 = 1 and bits 3:0 = port, a write to 0x6F launches a read. From the next cycle the data byte holds the selected byte: bits 15:8 of word offset/2 for an even offset, and bits 7:0 for an odd offset.
- R4: With control bits 7:5 = 001 and bit 4 = 0, a bus write to 0xA0 stores the written byte into the byte chosen by the last offset written.
- R5: Port value 0 selects the global group and values 1 to NUM_PORTS select the port groups. Each group has its own storage.
- R6: The upper byte of the recovery word (offset 0x2E) always reads 0x00, and writes to it are ignored.
- R7: If the table code is not 001, or the port value is above NUM_PORTS, triggered reads return 0x00 and writes to 0xA0 change no indirect register.
- R8: The data byte changes only on a write to 0x6F, so it keeps the last read result across writes to 0xA0.
- R9: A write to 0xA0 while control bit 4 = 1 changes no indirect register.
- R10: An offset of 2*NUM_WORDS (0x40) or above reads as 0x00, and writes to it are ignored. They do not alias onto lower offsets.
- R11: A bus read of any address other than 0x6E, 0x6F and 0xA0 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Direct bus write strobe |
| bus_addr | input | 8 | Direct bus byte address |
| bus_wdata | input | 8 | Direct bus write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
The assertions check on every cycle how the control-byte echo behaves. They also check that the data byte holds steady unless a read is triggered, and that it is zero after a read of a bad table, a bad port, an out-of-range offset or the reserved byte. They further check that read mode never enables a bank write and that unmapped addresses read zero. Only the bench scenarios can show that stored values reach the right group, word and byte. The same applies to the absence of aliasing through rejected ports or offsets, and to the reset defaults as seen through a full bridge access.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;

  localparam logic [7:0] ADDR_CTRL = 8'h6E;
  localparam logic [7:0] ADDR_OFFS = 8'h6F;
  localparam logic [7:0] ADDR_DATA = 8'hA0;

  localparam logic [2:0] TBL_PWR = 3'b001;

  typedef struct packed {
    logic [2:0] tbl;
    logic       rd;
    logic [3:0] port;
  } ctrl_t;

endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_bridge_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_WORDS = 32,
  localparam int GW = $clog2(NUM_PORTS + 1),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  ctrl_t           ctrl,
  input  logic [7:0]      offset,
  output logic            sel_ok,
  output logic [GW-1:0]   grp,
  output logic [WW-1:0]   word,
  output logic            hi_byte
);

  localparam logic [3:0] MAX_PORT = 4'(NUM_PORTS);
  localparam logic [8:0] OFF_LIM  = 9'(2 * NUM_WORDS);

  logic tbl_ok, port_ok, off_ok;

  always_comb begin
    tbl_ok  = (ctrl.tbl == TBL_PWR);
    port_ok = (ctrl.port <= MAX_PORT);
    off_ok  = ({1'b0, offset} < OFF_LIM);
    sel_ok  = tbl_ok && port_ok && off_ok;
    grp     = ctrl.port[GW-1:0];
    word    = offset[WW:1];
    hi_byte = ~offset[0];
  end

endmodule

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int          NUM_GROUPS = 5,
  parameter int          NUM_WORDS  = 32,
  parameter int          RECOV_WORD = 23,
  parameter logic [15:0] RECOV_INIT = 16'h0027,
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [GW-1:0] wgrp,
  input  logic [WW-1:0] wword,
  input  logic          whi,
  input  logic [7:0]    wbyte,
  input  logic [GW-1:0] rgrp,
  input  logic [WW-1:0] rword,
  input  logic          rhi,
  output logic [7:0]    rbyte
);

  logic [15:0] mem [NUM_GROUPS][NUM_WORDS];

  function automatic logic [15:0] wmask(input int w);
    return (w == RECOV_WORD) ? 16'h00FF : 16'hFFFF;
  endfunction

  function automatic logic [15:0] rstval(input int w);
    return (w == RECOV_WORD) ? RECOV_INIT : 16'h0000;
  endfunction

  logic [15:0] m_sel;
  assign m_sel = wmask(int'(wword));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int w = 0; w < NUM_WORDS; w++)
          mem[g][w] <= rstval(w) & wmask(w);
    end else if (we) begin
      if (whi)
        mem[wgrp][wword][15:8] <= (wbyte & m_sel[15:8]) |
                                  (mem[wgrp][wword][15:8] & ~m_sel[15:8]);
      else
        mem[wgrp][wword][7:0]  <= (wbyte & m_sel[7:0]) |
                                  (mem[wgrp][wword][7:0] & ~m_sel[7:0]);
    end
  end

  logic [15:0] rword_val;
  assign rword_val = mem[rgrp][rword];
  assign rbyte     = rhi ? rword_val[15:8] : rword_val[7:0];

endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import idx_bridge_pkg::*;
#(
  parameter int          NUM_PORTS  = 4,
  parameter int          NUM_WORDS  = 32,
  parameter int          RECOV_WORD = 23,
  parameter logic [15:0] RECOV_INIT = 16'h0027
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  localparam int NUM_GROUPS = NUM_PORTS + 1;
  localparam int GW = $clog2(NUM_GROUPS);
  localparam int WW = $clog2(NUM_WORDS);

  ctrl_t      ctrl_q;
  logic [7:0] off_q;
  logic [7:0] data_q;
  logic [7:0] rdata_q;

  // Two decoders: the read path sees the offset being written now,
  // the write path sees the stored offset.
  logic          rd_ok, wr_ok, rd_hi, wr_hi;
  logic [GW-1:0] rd_grp, wr_grp;
  logic [WW-1:0] rd_word, wr_word;

  idx_decode #(.NUM_PORTS(NUM_PORTS), .NUM_WORDS(NUM_WORDS)) rd_dec_i (
    .ctrl(ctrl_q), .offset(bus_wdata),
    .sel_ok(rd_ok), .grp(rd_grp), .word(rd_word), .hi_byte(rd_hi)
  );

  idx_decode #(.NUM_PORTS(NUM_PORTS), .NUM_WORDS(NUM_WORDS)) wr_dec_i (
    .ctrl(ctrl_q), .offset(off_q),
    .sel_ok(wr_ok), .grp(wr_grp), .word(wr_word), .hi_byte(wr_hi)
  );

  logic       trig_rd;
  logic       bank_we;
  logic [7:0] bank_rbyte;

  assign trig_rd = bus_we && (bus_addr == ADDR_OFFS) && ctrl_q.rd;
  assign bank_we = bus_we && (bus_addr == ADDR_DATA) && !ctrl_q.rd && wr_ok;

  idx_bank #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_WORDS(NUM_WORDS),
    .RECOV_WORD(RECOV_WORD), .RECOV_INIT(RECOV_INIT)
  ) bank_i (
    .clk(clk), .rst(rst),
    .we(bank_we), .wgrp(wr_grp), .wword(wr_word), .whi(wr_hi), .wbyte(bus_wdata),
    .rgrp(rd_grp), .rword(rd_word), .rhi(rd_hi), .rbyte(bank_rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      off_q  <= '0;
      data_q <= '0;
    end else begin
      if (bus_we && bus_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_we && bus_addr == ADDR_OFFS) off_q  <= bus_wdata;
      if (trig_rd) data_q <= rd_ok ? bank_rbyte : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (bus_addr)
        ADDR_CTRL: rdata_q <= ctrl_q;
        ADDR_OFFS: rdata_q <= off_q;
        ADDR_DATA: rdata_q <= data_q;
        default:   rdata_q <= 8'h00;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/idx_reg_bridge_chk.sv
module idx_reg_bridge_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_WORDS  = 32,
  parameter int RECOV_WORD = 23
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] ctrl_q,
  input logic [7:0] data_q,
  input logic       bank_we
);

  localparam logic [3:0] MAXP    = 4'(NUM_PORTS);
  localparam logic [8:0] OFF_LIM = 9'(2 * NUM_WORDS);
  localparam logic [7:0] RSV_OFF = 8'(2 * RECOV_WORD);

  logic offs_wr;
  assign offs_wr = bus_we && bus_addr == 8'h6F;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (data_q == 8'h00 && ctrl_q == 8'h00));

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h6E) |=> ctrl_q == $past(bus_wdata));

  assert_ctrl_echo_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && bus_addr == 8'h6E) |=> bus_rdata == $past(ctrl_q));

  assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (offs_wr && ctrl_q[7:4] == 4'h3 && ctrl_q[3:0] <= MAXP && bus_wdata == RSV_OFF)
    |=> data_q == 8'h00);

  assert_bad_table_R7: assert property (@(posedge clk) disable iff (rst)
    (offs_wr && ctrl_q[4] && ctrl_q[7:5] != 3'b001) |=> data_q == 8'h00);

  assert_bad_port_R7: assert property (@(posedge clk) disable iff (rst)
    (offs_wr && ctrl_q[4] && ctrl_q[3:0] > MAXP) |=> data_q == 8'h00);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !offs_wr |=> $stable(data_q));

  assert_rd_mode_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'hA0 && ctrl_q[4]) |-> !bank_we);

  assert_range_R10: assert property (@(posedge clk) disable iff (rst)
    (offs_wr && ctrl_q[4] && {1'b0, bus_wdata} >= OFF_LIM) |=> data_q == 8'h00);

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != 8'h6E && bus_addr != 8'h6F && bus_addr != 8'hA0)
    |=> bus_rdata == 8'h00);

endmodule

bind idx_reg_bridge idx_reg_bridge_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_WORDS(NUM_WORDS), .RECOV_WORD(RECOV_WORD)
) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
  .data_q(data_q), .bank_we(bank_we)
);

// File: tb/idx_reg_bridge_tb_top.sv
module idx_reg_bridge_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  idx_reg_bridge dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Vector fields: {op(1=read-check,0=write), addr, data, expected, req}
  localparam int NV = 64;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h6E, 8'h30, 8'h00, 4'd2},   // ctrl: table 001, read, global
    {1'b0, 8'h6F, 8'h2F, 8'h00, 4'd3},
    {1'b1, 8'hA0, 8'h00, 8'h27, 4'd1},   // R1 recovery default, R3 odd = low byte
    {1'b0, 8'h6F, 8'h2E, 8'h00, 4'd6},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd6},   // R6 reserved upper byte
    {1'b0, 8'h6E, 8'h20, 8'h00, 4'd4},   // write mode, global
    {1'b0, 8'h6F, 8'h2F, 8'h00, 4'd4},
    {1'b0, 8'hA0, 8'h5A, 8'h00, 4'd4},
    {1'b0, 8'h6E, 8'h30, 8'h00, 4'd4},
    {1'b0, 8'h6F, 8'h2F, 8'h00, 4'd4},
    {1'b1, 8'hA0, 8'h00, 8'h5A, 4'd4},   // R4 commit visible
    {1'b0, 8'h6E, 8'h20, 8'h00, 4'd6},
    {1'b0, 8'h6F, 8'h2E, 8'h00, 4'd6},
    {1'b0, 8'hA0, 8'hFF, 8'h00, 4'd6},
    {1'b0, 8'h6E, 8'h30, 8'h00, 4'd6},
    {1'b0, 8'h6F, 8'h2E, 8'h00, 4'd6},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd6},   // R6 write to reserved ignored
    {1'b0, 8'h6E, 8'h22, 8'h00, 4'd4},   // write port 2
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd4},
    {1'b0, 8'hA0, 8'hC3, 8'h00, 4'd4},
    {1'b0, 8'h6F, 8'h01, 8'h00, 4'd4},
    {1'b0, 8'hA0, 8'h3C, 8'h00, 4'd4},
    {1'b0, 8'h6E, 8'h32, 8'h00, 4'd3},   // read port 2
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd3},
    {1'b1, 8'hA0, 8'h00, 8'hC3, 4'd3},   // R3 even = high byte
    {1'b0, 8'h6F, 8'h01, 8'h00, 4'd3},
    {1'b1, 8'hA0, 8'h00, 8'h3C, 4'd3},   // R3 odd = low byte
    {1'b0, 8'h6E, 8'h30, 8'h00, 4'd5},
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd5},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd5},   // R5 global word 0 untouched
    {1'b0, 8'h6E, 8'h31, 8'h00, 4'd5},
    {1'b0, 8'h6F, 8'h2F, 8'h00, 4'd5},
    {1'b1, 8'hA0, 8'h00, 8'h27, 4'd5},   // R5 port 1 keeps its default
    {1'b0, 8'h6E, 8'h25, 8'h00, 4'd7},   // write, port 5 (invalid)
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd7},
    {1'b0, 8'hA0, 8'h77, 8'h00, 4'd7},
    {1'b0, 8'h6E, 8'h35, 8'h00, 4'd7},
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd7},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd7},   // R7 bad port reads zero
    {1'b0, 8'h6E, 8'h32, 8'h00, 4'd7},
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd7},
    {1'b1, 8'hA0, 8'h00, 8'hC3, 4'd7},   // R7 no alias of bad-port write
    {1'b0, 8'h6E, 8'h52, 8'h00, 4'd7},   // table 010, read, port 2
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd7},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd7},   // R7 bad table reads zero
    {1'b0, 8'h6E, 8'h32, 8'h00, 4'd9},
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd9},
    {1'b0, 8'hA0, 8'h11, 8'h00, 4'd9},   // data write in read mode
    {1'b1, 8'hA0, 8'h00, 8'hC3, 4'd8},   // R8 data byte held
    {1'b0, 8'h6F, 8'h00, 8'h00, 4'd9},
    {1'b1, 8'hA0, 8'h00, 8'hC3, 4'd9},   // R9 register unchanged
    {1'b0, 8'h6E, 8'h22, 8'h00, 4'd8},
    {1'b0, 8'h6F, 8'h01, 8'h00, 4'd8},
    {1'b0, 8'hA0, 8'h99, 8'h00, 4'd8},
    {1'b1, 8'hA0, 8'h00, 8'hC3, 4'd8},   // R8 last read kept after commit
    {1'b0, 8'h6E, 8'h32, 8'h00, 4'd4},
    {1'b0, 8'h6F, 8'h01, 8'h00, 4'd4},
    {1'b1, 8'hA0, 8'h00, 8'h99, 4'd4},   // R4 port 2 low byte rewritten
    {1'b0, 8'h6E, 8'h20, 8'h00, 4'd10},
    {1'b0, 8'h6F, 8'h40, 8'h00, 4'd10},
    {1'b0, 8'hA0, 8'hAB, 8'h00, 4'd10},
    {1'b0, 8'h6E, 8'h30, 8'h00, 4'd10},
    {1'b0, 8'h6F, 8'h40, 8'h00, 4'd10},
    {1'b1, 8'hA0, 8'h00, 8'h00, 4'd10}   // R10 out-of-range offset reads zero
  };

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_wdata = 8'h00;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bus_check(8'h6E, 8'h00, "R1");
    bus_check(8'hA0, 8'h00, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28])
        bus_check(VEC[i][27:20], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
      else
        bus_write(VEC[i][27:20], VEC[i][19:12]);
    end

    // R2 offset and control read back
    bus_check(8'h6F, 8'h40, "R2");
    bus_check(8'h6E, 8'h30, "R2");
    // R10 the ignored write to 0x40 did not land on offset 0x00
    bus_write(8'h6F, 8'h00);
    bus_check(8'hA0, 8'h00, "R10");
    // R11 unmapped addresses
    bus_check(8'h55, 8'h00, "R11");
    bus_check(8'hA1, 8'h00, "R11");

    // R1 second reset restores defaults
    @(negedge clk); bus_we = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bus_check(8'h6E, 8'h00, "R1");
    bus_check(8'h6F, 8'h00, "R1");
    bus_check(8'hA0, 8'h00, "R1");
    bus_write(8'h6E, 8'h34);
    bus_write(8'h6F, 8'h2F);
    bus_check(8'hA0, 8'h27, "R1");
    bus_write(8'h6E, 8'h32);
    bus_write(8'h6F, 8'h00);
    bus_check(8'hA0, 8'h00, "R1");
    // R3 back-to-back triggered reads
    bus_write(8'h6F, 8'h2F);
    bus_write(8'h6F, 8'h2E);
    bus_check(8'hA0, 8'h00, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule